// File: doc/BRIEF.md
# Timer Output Compare Unit

This block sits beside a free-running timer and turns its count into events on a single output pin. Two compare channels each hold a compare value. A channel matches when the count input steps onto its value. On a match the channel applies its own action to a shared output latch: hold, set, clear or invert. It also raises a sticky event flag, and an enabled flag drives the interrupt output. Software can stage new compare values in a buffer that is committed on the next match. It can also force the latch directly, and the pin can serve as an input whose level is read back through a synchronizer.

The block is reached through a small word-wide register bus. Address 0 holds the control word, address 1 holds the compare value of channel 0, and address 2 holds that of channel 1. Writes take effect at the clock edge. Reads are combinational. The pin is driven from the latch, and a control bit sets its direction.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset, pin_out, pin_oe and irq are 0, the control word reads 0 (apart from the pin status in bit 12), and both compare values read 0.
- R2: A channel matches only in a cycle where cnt_in differs from its value in the previous cycle and equals that channel's active compare value. A count that holds still on the compare value produces no further match.
- R3: The action field of channel 0 is control bits [1:0] and that of channel 1 is bits [3:2]. Code 00 leaves the latch unchanged, 01 sets it, 10 clears it and 11 inverts it. pin_out shows the result after the clock edge that ends the match cycle.
- R4: When both channels match in one cycle, channel 0's action is applied first and channel 1's action is applied to that result.
- R5: With control bit 8 at 0, a write to a compare address changes the active value at once. With bit 8 at 1, the write only fills a buffer, and the active value (the value read back at that address) takes the buffer contents at the edge ending a match on that channel.
- R6: Writing the control word with bit 11 at 1 loads bit 10 of the written word into the output latch. Bit 11 always reads 0, and bit 10 reads back as written.
- R7: If a software load and a compare match with a non-zero action fall in the same cycle, the latch takes the compare result.
- R8: Flag bits 6 (channel 0) and 7 (channel 1) set on a match and stay set. A control write with 1 in a flag bit clears that flag, while a 0 leaves it unchanged. A write to a channel's compare address also clears that channel's flag.
- R9: If a clear of either kind meets a match of the same channel in one cycle, the flag ends up set.
- R10: irq is 1 exactly when (flag0 and enable bit 4) or (flag1 and enable bit 5) holds.
- R11: Control bit 9 drives pin_oe. Read-only bit 12 reports pin_in after a two-flop synchronizer: a level change on pin_in appears there after two clock edges.
- R12: Reading address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| cnt_in | input | 16 | Count value from the external timer |
| pin_in | input | 1 | Level sensed on the pin |
| pin_out | output | 1 | Output latch value driven to the pin |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that pin_in and cnt_in hold steady at their reset values while reset is applied, and that the bus carries at most one write per cycle. They check the synchronizer delay only once the block has been out of reset for three edges. The bench drives every input on the falling clock edge, keeps pin_in low and the count at zero through reset, and makes each count change a deliberate step. Matches and clears that coincide do so because the bench arranges it, never by accident of timing.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    localparam int NCH = 2;

    // control word bit positions
    localparam int B_ACT0   = 0;
    localparam int B_ACT1   = 2;
    localparam int B_IEN0   = 4;
    localparam int B_FLG0   = 6;
    localparam int B_SHADOW = 8;
    localparam int B_OE     = 9;
    localparam int B_ODATA  = 10;
    localparam int B_DRIVE  = 11;
    localparam int B_STAT   = 12;
    localparam int CTRL_BITS = 13;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_SET  = 2'b01,
        ACT_CLR  = 2'b10,
        ACT_TGL  = 2'b11
    } act_e;

    function automatic logic act_apply(input logic cur, input act_e a);
        logic r;
        case (a)
            ACT_SET:  r = 1'b1;
            ACT_CLR:  r = 1'b0;
            ACT_TGL:  r = ~cur;
            default:  r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcu_sync.sv
module tcu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d = q;
        d.sh[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            d.sh[i] = q.sh[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout = q.sh[STAGES-1];
endmodule

// File: rtl/tcu_channel.sv
module tcu_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shadow_en,
    input  logic         cnt_step,
    input  logic [W-1:0] cnt_in,
    input  logic         data_wr,
    input  logic [W-1:0] wdata,
    input  logic         flag_clr,
    output logic         match,
    output logic         flag,
    output logic [W-1:0] cmp_val
);
    typedef struct packed {
        logic [W-1:0] cmp;
        logic [W-1:0] stage;
        logic         flg;
    } ch_t;

    ch_t d, q;

    always_comb begin
        d = q;
        match = cnt_step && (cnt_in == q.cmp);
        if (data_wr) begin
            d.stage = wdata;
            if (!shadow_en) d.cmp = wdata;
        end
        if (match && shadow_en) d.cmp = q.stage;
        if (flag_clr || data_wr) d.flg = 1'b0;
        if (match) d.flg = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag    = q.flg;
    assign cmp_val = q.cmp;

    // a match always leaves the flag set, whatever clear arrives with it
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    // flag stays set without a clear
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr && !data_wr) |=> flag);

    // buffered mode: active value only moves on a match
    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_en && !match) |=> $stable(cmp_val));

    // direct mode: a write lands in the active value at once
    assert_direct_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!shadow_en && data_wr) |=> (cmp_val == $past(wdata)));
endmodule

// File: rtl/tcu_latch.sv
module tcu_latch
    import tcu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  act_e           act0,
    input  act_e           act1,
    input  logic           preload,
    input  logic           pre_val,
    output logic           q_out
);
    typedef struct packed {
        logic lat;
    } lat_t;

    lat_t d, q;
    logic cmp_act;
    logic after0;

    always_comb begin
        d = q;
        after0  = hit[0] ? act_apply(q.lat, act0) : q.lat;
        cmp_act = (hit[0] && act0 != ACT_HOLD) || (hit[1] && act1 != ACT_HOLD);
        if (cmp_act) begin
            d.lat = hit[1] ? act_apply(after0, act1) : after0;
        end else if (preload) begin
            d.lat = pre_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign q_out = q.lat;

    // channel 1 acts last
    assert_ch1_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && act1 == ACT_SET) |=> q_out);

    assert_cmp_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && act0 == ACT_CLR && !hit[1]) |=> !q_out);

    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && !hit[1] && act0 == ACT_TGL) |=> (q_out != $past(q_out)));

    assert_preload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (preload && !hit[0] && !hit[1]) |=> (q_out == $past(pre_val)));
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit
    import tcu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] cnt_in,
    input  logic         pin_in,
    output logic         pin_out,
    output logic         pin_oe,
    output logic         irq
);
    localparam int PAD = W - CTRL_BITS;

    typedef struct packed {
        logic [NCH-1:0][1:0] act;
        logic [NCH-1:0]      ien;
        logic                shadow;
        logic                oe;
        logic                odata;
    } ctrl_t;

    typedef struct packed {
        ctrl_t        ctrl;
        logic [W-1:0] cnt;
        logic [1:0]   age;
    } top_t;

    top_t d, q;

    logic           ctrl_wr;
    logic           cnt_step;
    logic           pin_stat;
    logic [NCH-1:0] match;
    logic [NCH-1:0] flag;
    logic [NCH-1:0] data_wr;
    logic [NCH-1:0] flag_clr;
    logic [W-1:0]   cmp_val [NCH];

    assign ctrl_wr  = bus_wr && (bus_addr == 2'd0);
    assign cnt_step = (cnt_in != q.cnt);

    always_comb begin
        d = q;
        d.cnt = cnt_in;
        if (q.age != 2'd3) d.age = q.age + 2'd1;
        if (ctrl_wr) begin
            for (int i = 0; i < NCH; i++) begin
                d.ctrl.act[i] = bus_wdata[B_ACT0 + 2*i +: 2];
                d.ctrl.ien[i] = bus_wdata[B_IEN0 + i];
            end
            d.ctrl.shadow = bus_wdata[B_SHADOW];
            d.ctrl.oe     = bus_wdata[B_OE];
            d.ctrl.odata  = bus_wdata[B_ODATA];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            assign data_wr[g]  = bus_wr && (bus_addr == 2'(g + 1));
            assign flag_clr[g] = ctrl_wr && bus_wdata[B_FLG0 + g];

            tcu_channel #(.W(W)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .shadow_en (q.ctrl.shadow),
                .cnt_step  (cnt_step),
                .cnt_in    (cnt_in),
                .data_wr   (data_wr[g]),
                .wdata     (bus_wdata),
                .flag_clr  (flag_clr[g]),
                .match     (match[g]),
                .flag      (flag[g]),
                .cmp_val   (cmp_val[g])
            );
        end
    endgenerate

    tcu_latch u_lat (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (match),
        .act0    (act_e'(q.ctrl.act[0])),
        .act1    (act_e'(q.ctrl.act[1])),
        .preload (ctrl_wr && bus_wdata[B_DRIVE]),
        .pre_val (bus_wdata[B_ODATA]),
        .q_out   (pin_out)
    );

    tcu_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (pin_stat)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            2'd0: bus_rdata = {{PAD{1'b0}}, pin_stat, 1'b0, q.ctrl.odata,
                               q.ctrl.oe, q.ctrl.shadow, flag, q.ctrl.ien,
                               q.ctrl.act[1], q.ctrl.act[0]};
            2'd1: bus_rdata = cmp_val[0];
            2'd2: bus_rdata = cmp_val[1];
            default: bus_rdata = '0;
        endcase
    end

    assign pin_oe = q.ctrl.oe;
    assign irq    = |(flag & q.ctrl.ien);

    // pin status trails the pin by two edges once the pipe is filled
    assert_sync_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.age == 2'd3) |-> (pin_stat == $past(pin_in, 2)));

    // a channel whose flag rose must have matched in the cycle before
    assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[0]) |-> $past(match[0]));
endmodule

// File: tb/sim_tmr_cmp_unit.sv
module sim_tmr_cmp_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] cnt_in = '0;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tmr_cmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // {wr, addr, wdata, cnt, exp pin_out, exp irq}
    localparam int NV = 13;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 2'd1, 16'h0005, 16'd0, 1'b0, 1'b0},
        {1'b1, 2'd2, 16'h0009, 16'd0, 1'b0, 1'b0},
        {1'b1, 2'd0, 16'h0019, 16'd0, 1'b0, 1'b0},
        {1'b0, 2'd0, 16'h0000, 16'd4, 1'b0, 1'b0},
        {1'b0, 2'd0, 16'h0000, 16'd5, 1'b1, 1'b1},
        {1'b0, 2'd0, 16'h0000, 16'd5, 1'b1, 1'b1},
        {1'b0, 2'd0, 16'h0000, 16'd9, 1'b0, 1'b1},
        {1'b1, 2'd0, 16'h0059, 16'd9, 1'b0, 1'b0},
        {1'b0, 2'd0, 16'h0000, 16'd5, 1'b1, 1'b1},
        {1'b1, 2'd1, 16'h0005, 16'd6, 1'b1, 1'b0},
        {1'b1, 2'd0, 16'h003F, 16'd6, 1'b1, 1'b1},
        {1'b0, 2'd0, 16'h0000, 16'd5, 1'b0, 1'b1},
        {1'b0, 2'd0, 16'h0000, 16'd9, 1'b1, 1'b1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle from a falling edge to the next falling edge
    task automatic cyc(input logic wr, input logic [1:0] a, input logic [15:0] dat,
                       input logic [15:0] cnt);
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = dat;
        cnt_in = cnt;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_out", {15'd0, pin_out}, 16'd0);
        check("R1 pin_oe", {15'd0, pin_oe}, 16'd0);
        check("R1 irq", {15'd0, irq}, 16'd0);
        peek(2'd0, rv); check("R1 ctrl", rv, 16'h0000);
        peek(2'd1, rv); check("R1 cmp0", rv, 16'h0000);

        // table: R2 R3 R8 R10
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][36], VEC[i][35:34], VEC[i][33:18], VEC[i][17:2]);
            check($sformatf("R3 vec%0d pin_out", i), {15'd0, pin_out}, {15'd0, VEC[i][1]});
            check($sformatf("R10 vec%0d irq", i), {15'd0, irq}, {15'd0, VEC[i][0]});
        end

        // R9: clear flag0 in the cycle it matches, flag1 clears
        cyc(1'b1, 2'd0, 16'h00FF, 16'd5);
        peek(2'd0, rv); check("R9 flags after clear+match", {14'd0, rv[7:6]}, 16'd1);
        check("R3 toggle", {15'd0, pin_out}, 16'd0);

        // R2: stalled count does not re-set a cleared flag
        cyc(1'b1, 2'd0, 16'h007F, 16'd5);
        cyc(1'b0, 2'd0, 16'h0000, 16'd5);
        peek(2'd0, rv); check("R2 stall no retrigger", {14'd0, rv[7:6]}, 16'd0);
        check("R10 irq low", {15'd0, irq}, 16'd0);

        // R4: both channels match together
        cyc(1'b1, 2'd1, 16'd20, 16'd5);
        cyc(1'b1, 2'd2, 16'd20, 16'd5);
        cyc(1'b1, 2'd0, 16'h0006, 16'd5);
        cyc(1'b0, 2'd0, 16'h0000, 16'd20);
        check("R4 ch1 set last", {15'd0, pin_out}, 16'd1);
        cyc(1'b1, 2'd0, 16'h0009, 16'd21);
        cyc(1'b0, 2'd0, 16'h0000, 16'd20);
        check("R4 ch1 clear last", {15'd0, pin_out}, 16'd0);

        // R6: software load of the latch
        cyc(1'b1, 2'd0, 16'h0C00, 16'd21);
        check("R6 preload high", {15'd0, pin_out}, 16'd1);
        peek(2'd0, rv); check("R6 drive reads 0", rv & 16'h0C00, 16'h0400);
        cyc(1'b1, 2'd0, 16'h0800, 16'd21);
        check("R6 preload low", {15'd0, pin_out}, 16'd0);

        // R7: compare action beats software load
        cyc(1'b1, 2'd0, 16'h0002, 16'd21);
        cyc(1'b1, 2'd0, 16'h0C02, 16'd20);
        check("R7 compare wins", {15'd0, pin_out}, 16'd0);

        // R8 / R9 for compare data writes
        cyc(1'b1, 2'd1, 16'd20, 16'd21);
        peek(2'd0, rv); check("R8 data write clears flag0", {15'd0, rv[6]}, 16'd0);
        cyc(1'b1, 2'd2, 16'd20, 16'd20);
        peek(2'd0, rv); check("R9 data write vs match flag1", {15'd0, rv[7]}, 16'd1);

        // R5: buffered compare update
        cyc(1'b1, 2'd0, 16'h0100, 16'd22);
        cyc(1'b1, 2'd1, 16'd30, 16'd22);
        peek(2'd1, rv); check("R5 buffered not active", rv, 16'd20);
        cyc(1'b0, 2'd0, 16'h0000, 16'd20);
        peek(2'd1, rv); check("R5 committed on match", rv, 16'd30);

        // R11: direction and synchronizer
        cyc(1'b1, 2'd0, 16'h0200, 16'd22);
        check("R11 pin_oe", {15'd0, pin_oe}, 16'd1);
        pin_in = 1'b1;
        @(negedge clk);
        peek(2'd0, rv); check("R11 status after 1 edge", {15'd0, rv[12]}, 16'd0);
        @(negedge clk);
        peek(2'd0, rv); check("R11 status after 2 edges", {15'd0, rv[12]}, 16'd1);

        // R12: unused address
        peek(2'd3, rv); check("R12 addr3", rv, 16'd0);

        finish_run();
    end
endmodule